// File: doc/BRIEF.md
# In-Order Completion Reorder Buffer

This block keeps instructions in program order while they execute out of order. A dispatch stage asks for up to four slots per cycle. If enough slots are free, the block grants the request and returns one tag per instruction. The tags are consecutive slot numbers starting at the current tail. Each slot also stores a 3-bit code naming the functional unit the instruction was sent to.

Execution units report against a tag on two ports. The start port marks that execution has begun. The finish port marks that the result is ready and records whether the instruction raised an exception.

Each cycle, a completion stage looks at the oldest slots and retires up to four finished instructions, strictly from the head. It stops at the first slot that is not finished. An excepting instruction is retired only when it is the oldest one, and only by itself. In that same cycle every younger slot is discarded, so the buffer is empty afterwards. All slot and count sizes are parameters. The defaults are 16 slots, 4-wide dispatch and 4-wide retire.

Top module: `inorder_retire_buf`

## Requirements
- R1: After a synchronous reset the buffer is empty, and all of the following read 0: `ret_valid`, `ret_exc`, `flush_o` and `full_o`. A request of four is granted.
- R2: When `disp_cnt` is 1 to 4, `disp_ack` is high in the same cycle if the number of free slots is at least `disp_cnt` and no flush is being taken that cycle. Lane i of `disp_tags` then reads (tail + i) mod 16, and those slots are allocated at the next rising edge.
- R3: `full_o` is registered and reads 1 after any edge that leaves fewer than four free slots. A request larger than the number of free slots is refused as a whole, and no slot is allocated.
- R4: A start report moves a slot from allocated to executing. A start report on a slot in any other state has no effect.
- R5: A finish report moves a slot from executing to finished and stores the exception flag. A finish report on a slot that is not executing has no effect, so that slot never retires from it.
- R6: Retirement takes finished slots from the head, in order, up to four per cycle, and stops at the first slot that is not finished. The result shows on the registered outputs one edge later: `ret_valid` is filled from lane 0 upward, and lane k carries the k-th retired tag and its unit code.
- R7: A finished slot with the exception flag set retires only from lane 0 and only by itself. That cycle also shows `ret_exc`=1 and `flush_o`=1, and every other slot returns to free. Retirement of older slots stops in front of the excepting slot.
- R8: Unit codes are 0 and 1 for the two simple integer units, 2 for complex integer, 3 for floating point, 4 for load/store and 5 for branch. The code given at dispatch is returned at retirement.
- R9: Tags wrap modulo 16. The head and tail pointers carry one extra wrap bit, so that 16 occupied slots count as full and not as empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| disp_cnt | input | 3 | Number of instructions offered for dispatch this cycle (0 to 4) |
| disp_unit | input | 12 | Unit code per dispatch lane, lane i in bits [3i+2:3i] |
| disp_ack | output | 1 | The whole dispatch request is accepted this cycle |
| disp_tags | output | 16 | Tag per dispatch lane, lane i in bits [4i+3:4i] |
| full_o | output | 1 | Fewer than four free slots |
| ex_valid | input | 1 | Execution-start report |
| ex_tag | input | 4 | Tag of the starting instruction |
| fin_valid | input | 1 | Finish report |
| fin_tag | input | 4 | Tag of the finishing instruction |
| fin_exc | input | 1 | The finishing instruction raised an exception |
| ret_valid | output | 4 | Retire lanes in use, filled from lane 0 |
| ret_tags | output | 16 | Retired tag per lane |
| ret_units | output | 12 | Retired unit code per lane |
| ret_exc | output | 1 | The lane 0 retirement is an exception |
| flush_o | output | 1 | All younger slots were discarded at this edge |

## Verification
Results fall due at fixed edges.
- **Grant and tags:** these depend only on registered pointers, so they are read in the same cycle the request is driven.
- **Start or finish report:** this changes slot state at the next edge. The matching retire lanes appear one edge after that.
- **Flush:** it follows one edge after the retirement of the older slots that sat in front of the excepting one.
- **`full_o`:** it reflects the occupancy left by the edge that just passed.

The bench drives inputs on the falling edge and reads each result in the low phase after the edge at which it is due. It also checks that a retire pulse is absent one cycle early and gone one cycle later.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_ALLOC = 2'd1,
    ST_EXEC  = 2'd2,
    ST_FIN   = 2'd3
  } slot_state_t;

  typedef enum logic [2:0] {
    U_INT_A  = 3'd0,
    U_INT_B  = 3'd1,
    U_CPLX   = 3'd2,
    U_FP     = 3'd3,
    U_LDST   = 3'd4,
    U_BRANCH = 3'd5
  } unit_code_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  localparam int PTR_W  = $clog2(DEPTH) + 1,
  localparam int CNT_W  = $clog2(DISP_W + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  push_cnt,
  input  logic [RCNT_W-1:0] pop_cnt,
  input  logic              flush,
  output logic [PTR_W-1:0]  head_q,
  output logic [PTR_W-1:0]  tail_q,
  output logic [PTR_W-1:0]  occ,
  output logic [PTR_W-1:0]  free_cnt,
  output logic              full_q
);
  logic [PTR_W-1:0] head_d, tail_d, occ_d, free_d;

  // Pointer difference works modulo 2^PTR_W because DEPTH is a power of two.
  assign head_d   = head_q + PTR_W'(pop_cnt);
  assign tail_d   = flush ? head_d : (tail_q + PTR_W'(push_cnt));
  assign occ      = tail_q - head_q;
  assign free_cnt = PTR_W'(DEPTH) - occ;
  assign occ_d    = tail_d - head_d;
  assign free_d   = PTR_W'(DEPTH) - occ_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      full_q <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      full_q <= (free_d < PTR_W'(DISP_W));
    end
  end

  // R9: occupancy never exceeds the slot count
  p_occ_bound_r9: assert property (@(posedge clk) disable iff (rst)
    occ <= PTR_W'(DEPTH));

  // R6: never retire more slots than are occupied
  p_pop_bound_r6: assert property (@(posedge clk) disable iff (rst)
    PTR_W'(pop_cnt) <= occ);
endmodule

// File: rtl/rob_slot_bank.sv
module rob_slot_bank
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int UNIT_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEPTH-1:0]  alloc_mask,
  input  logic [UNIT_W-1:0] alloc_unit [DEPTH],
  input  logic              ex_valid,
  input  logic [IDX_W-1:0]  ex_tag,
  input  logic              fin_valid,
  input  logic [IDX_W-1:0]  fin_tag,
  input  logic              fin_exc,
  input  logic [DEPTH-1:0]  free_mask,
  output slot_state_t       st_q [DEPTH],
  output logic [UNIT_W-1:0] unit_q [DEPTH],
  output logic [DEPTH-1:0]  exc_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic ex_hit, fin_hit;
    assign ex_hit  = ex_valid  && (ex_tag  == IDX_W'(g));
    assign fin_hit = fin_valid && (fin_tag == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]  <= ST_FREE;
        exc_q[g] <= 1'b0;
      end else if (free_mask[g]) begin
        st_q[g] <= ST_FREE;
      end else if (alloc_mask[g]) begin
        st_q[g]  <= ST_ALLOC;
        exc_q[g] <= 1'b0;
      end else if (ex_hit && st_q[g] == ST_ALLOC) begin
        st_q[g] <= ST_EXEC;
      end else if (fin_hit && st_q[g] == ST_EXEC) begin
        st_q[g]  <= ST_FIN;
        exc_q[g] <= fin_exc;
      end
    end

    // Payload has no reset; it is only read once the slot is finished.
    always_ff @(posedge clk) begin
      if (alloc_mask[g]) unit_q[g] <= alloc_unit[g];
    end

    // R4: a slot only enters execute from allocate
    p_exec_from_alloc_r4: assert property (@(posedge clk) disable iff (rst)
      (st_q[g] == ST_EXEC && $past(st_q[g]) != ST_EXEC) |-> $past(st_q[g]) == ST_ALLOC);

    // R5: a slot only becomes finished from execute
    p_fin_from_exec_r5: assert property (@(posedge clk) disable iff (rst)
      (st_q[g] == ST_FIN && $past(st_q[g]) != ST_FIN) |-> $past(st_q[g]) == ST_EXEC);
  end
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RET_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH) + 1,
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  slot_state_t       st_q [DEPTH],
  input  logic [DEPTH-1:0]  exc_q,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [PTR_W-1:0]  occ,
  output logic [IDX_W-1:0]  slot_idx [RET_W],
  output logic [RCNT_W-1:0] ret_n,
  output logic              take_flush
);
  for (genvar k = 0; k < RET_W; k++) begin : g_lane
    assign slot_idx[k] = head_idx + IDX_W'(k);
  end

  always_comb begin
    logic stop;
    stop       = 1'b0;
    ret_n      = '0;
    take_flush = 1'b0;
    for (int k = 0; k < RET_W; k++) begin
      if (!stop) begin
        if (PTR_W'(k) < occ && st_q[slot_idx[k]] == ST_FIN) begin
          if (exc_q[slot_idx[k]]) begin
            if (k == 0) begin
              ret_n      = RCNT_W'(1);
              take_flush = 1'b1;
            end
            stop = 1'b1;
          end else begin
            ret_n = ret_n + RCNT_W'(1);
          end
        end else begin
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int UNIT_W = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH) + 1,
  localparam int CNT_W  = $clog2(DISP_W + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         disp_cnt,
  input  logic [DISP_W*UNIT_W-1:0] disp_unit,
  output logic                     disp_ack,
  output logic [DISP_W*IDX_W-1:0]  disp_tags,
  output logic                     full_o,
  input  logic                     ex_valid,
  input  logic [IDX_W-1:0]         ex_tag,
  input  logic                     fin_valid,
  input  logic [IDX_W-1:0]         fin_tag,
  input  logic                     fin_exc,
  output logic [RET_W-1:0]         ret_valid,
  output logic [RET_W*IDX_W-1:0]   ret_tags,
  output logic [RET_W*UNIT_W-1:0]  ret_units,
  output logic                     ret_exc,
  output logic                     flush_o
);
  logic [PTR_W-1:0]  head_q, tail_q, occ, free_cnt;
  logic [CNT_W-1:0]  push_cnt;
  logic [RCNT_W-1:0] ret_n;
  logic              take_flush;
  logic [IDX_W-1:0]  disp_idx [DISP_W];
  logic [IDX_W-1:0]  slot_idx [RET_W];
  logic [DEPTH-1:0]  alloc_mask, free_mask, exc_q;
  logic [UNIT_W-1:0] alloc_unit [DEPTH];
  logic [UNIT_W-1:0] unit_q [DEPTH];
  slot_state_t       st_q [DEPTH];

  // ---- dispatch: grant and tag lanes from the registered tail ----
  assign disp_ack = (disp_cnt != '0) && (disp_cnt <= CNT_W'(DISP_W)) &&
                    (PTR_W'(disp_cnt) <= free_cnt) && !take_flush;
  assign push_cnt = disp_ack ? disp_cnt : '0;

  for (genvar i = 0; i < DISP_W; i++) begin : g_disp
    assign disp_idx[i] = tail_q[IDX_W-1:0] + IDX_W'(i);
    assign disp_tags[i*IDX_W +: IDX_W] = disp_idx[i];
  end

  always_comb begin
    alloc_mask = '0;
    for (int e = 0; e < DEPTH; e++) alloc_unit[e] = '0;
    for (int i = 0; i < DISP_W; i++) begin
      if (disp_ack && CNT_W'(i) < disp_cnt) begin
        alloc_mask[disp_idx[i]] = 1'b1;
        alloc_unit[disp_idx[i]] = disp_unit[i*UNIT_W +: UNIT_W];
      end
    end
  end

  // ---- release: retired slots, or every slot on an exception ----
  always_comb begin
    free_mask = '0;
    if (take_flush) begin
      free_mask = '1;
    end else begin
      for (int k = 0; k < RET_W; k++) begin
        if (RCNT_W'(k) < ret_n) free_mask[slot_idx[k]] = 1'b1;
      end
    end
  end

  rob_ptrs #(.DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .push_cnt (push_cnt),
    .pop_cnt  (ret_n),
    .flush    (take_flush),
    .head_q   (head_q),
    .tail_q   (tail_q),
    .occ      (occ),
    .free_cnt (free_cnt),
    .full_q   (full_o)
  );

  rob_slot_bank #(.DEPTH(DEPTH), .UNIT_W(UNIT_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .alloc_mask (alloc_mask),
    .alloc_unit (alloc_unit),
    .ex_valid   (ex_valid),
    .ex_tag     (ex_tag),
    .fin_valid  (fin_valid),
    .fin_tag    (fin_tag),
    .fin_exc    (fin_exc),
    .free_mask  (free_mask),
    .st_q       (st_q),
    .unit_q     (unit_q),
    .exc_q      (exc_q)
  );

  rob_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W)) u_sel (
    .st_q       (st_q),
    .exc_q      (exc_q),
    .head_idx   (head_q[IDX_W-1:0]),
    .occ        (occ),
    .slot_idx   (slot_idx),
    .ret_n      (ret_n),
    .take_flush (take_flush)
  );

  // ---- registered completion outputs ----
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= '0;
      ret_tags  <= '0;
      ret_units <= '0;
      ret_exc   <= 1'b0;
      flush_o   <= 1'b0;
    end else begin
      for (int k = 0; k < RET_W; k++) begin
        ret_valid[k]                 <= (RCNT_W'(k) < ret_n);
        ret_tags[k*IDX_W +: IDX_W]   <= slot_idx[k];
        ret_units[k*UNIT_W +: UNIT_W] <= unit_q[slot_idx[k]];
      end
      ret_exc <= take_flush;
      flush_o <= take_flush;
    end
  end

  // R7: an exception retires alone, from lane 0
  p_flush_alone_r7: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (ret_valid == RET_W'(1)) && ret_exc);

  // R7: after a flush edge the buffer holds nothing
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> occ == '0);

  // R6: retire lanes are filled from lane 0 with no gaps
  p_ret_contig_r6: assert property (@(posedge clk) disable iff (rst)
    (ret_valid & (ret_valid + RET_W'(1))) == '0);

  // R3: a full-width request is never granted while full is shown
  p_full_refuse_r3: assert property (@(posedge clk) disable iff (rst)
    (full_o && disp_cnt == CNT_W'(DISP_W)) |-> !disp_ack);
endmodule

// File: tb/sim_inorder_retire_buf.sv
module sim_inorder_retire_buf;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [2:0]  disp_cnt;
  logic [11:0] disp_unit;
  logic        disp_ack;
  logic [15:0] disp_tags;
  logic        full_o;
  logic        ex_valid;
  logic [3:0]  ex_tag;
  logic        fin_valid;
  logic [3:0]  fin_tag;
  logic        fin_exc;
  logic [3:0]  ret_valid;
  logic [15:0] ret_tags;
  logic [11:0] ret_units;
  logic        ret_exc;
  logic        flush_o;

  int checks = 0;
  int failures = 0;
  int exp_tail = 0;
  bit done = 1'b0;

  inorder_retire_buf u0 (
    .clk(clk), .rst(rst), .disp_cnt(disp_cnt), .disp_unit(disp_unit),
    .disp_ack(disp_ack), .disp_tags(disp_tags), .full_o(full_o),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .fin_valid(fin_valid),
    .fin_tag(fin_tag), .fin_exc(fin_exc), .ret_valid(ret_valid),
    .ret_tags(ret_tags), .ret_units(ret_units), .ret_exc(ret_exc),
    .flush_o(flush_o)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dispatch(input int cnt, input logic [11:0] units,
                          input bit exp_ack, input string req);
    disp_cnt  = 3'(cnt);
    disp_unit = units;
    #1;
    chk(int'(disp_ack), int'(exp_ack), req);
    if (exp_ack)
      for (int i = 0; i < cnt; i++)
        chk(int'(disp_tags[i*4 +: 4]), (exp_tail + i) % 16, {req, " tag lane"});
    step();
    disp_cnt = '0;
    if (exp_ack) exp_tail = (exp_tail + cnt) % 16;
  endtask

  task automatic start_ex(input int tag);
    ex_valid = 1'b1;
    ex_tag   = 4'(tag);
    step();
    ex_valid = 1'b0;
  endtask

  task automatic finish(input int tag, input bit exc);
    fin_valid = 1'b1;
    fin_tag   = 4'(tag);
    fin_exc   = exc;
    step();
    fin_valid = 1'b0;
    fin_exc   = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset;
    chk(int'(ret_valid), 0, "R1 ret_valid");
    chk(int'(ret_exc), 0, "R1 ret_exc");
    chk(int'(flush_o), 0, "R1 flush_o");
    chk(int'(full_o), 0, "R1 full_o");
    disp_cnt = 3'd4;
    #1;
    chk(int'(disp_ack), 1, "R1 grant of four when empty");
    disp_cnt = '0;
  endtask

  // R2 R4 R5 R6 R8: four in one request, finished out of order, retired together
  task automatic t_burst;
    dispatch(4, {3'd5, 3'd4, 3'd3, 3'd2}, 1'b1, "R2 burst");
    for (int t = 0; t < 4; t++) start_ex(t);
    for (int t = 3; t >= 1; t--) begin
      finish(t, 1'b0);
      chk(int'(ret_valid), 0, "R6 held while head unfinished");
    end
    finish(0, 1'b0);
    chk(int'(ret_valid), 0, "R6 not yet due");
    step();
    chk(int'(ret_valid), 15, "R6 four retire in one cycle");
    chk(int'(ret_tags), 16'h3210, "R6 retire tag order");
    chk(int'(ret_units), int'({3'd5, 3'd4, 3'd3, 3'd2}), "R8 unit codes returned");
    step();
    chk(int'(ret_valid), 0, "R6 one-cycle retire pulse");
  endtask

  // R4 R5: reports on slots in the wrong state are ignored
  task automatic t_ignored;
    dispatch(1, 12'd0, 1'b1, "R2 single");           // tag 4
    finish(4, 1'b0);                                 // allocated, not executing
    step();
    chk(int'(ret_valid), 0, "R5 finish without start ignored");
    start_ex(4);
    finish(4, 1'b0);
    step();
    chk(int'(ret_valid), 1, "R5 retire after start and finish");
    chk(int'(ret_tags[3:0]), 4, "R5 tag");
    start_ex(5);                                     // slot 5 free
    dispatch(1, 12'd1, 1'b1, "R2 single");           // tag 5
    finish(5, 1'b0);
    step();
    chk(int'(ret_valid), 0, "R4 start on free slot ignored");
    start_ex(5);
    finish(5, 1'b0);
    step();
    chk(int'(ret_valid), 1, "R4 retire after proper start");
    chk(int'(ret_units[2:0]), 1, "R8 unit code");
  endtask

  // R3 R9: fill up, refuse, wrap, drain
  task automatic t_full;
    dispatch(4, 12'd0, 1'b1, "R2 fill");
    dispatch(4, 12'd0, 1'b1, "R2 fill");
    dispatch(4, 12'd0, 1'b1, "R2 fill");
    chk(int'(full_o), 0, "R3 four free is not full");
    dispatch(1, 12'd0, 1'b1, "R2 fill");
    chk(int'(full_o), 1, "R3 three free shows full");
    dispatch(4, 12'd0, 1'b0, "R3 oversized request refused");
    dispatch(3, 12'd0, 1'b1, "R9 wrapped tags");
    chk(int'(full_o), 1, "R9 sixteen occupied is full");
    dispatch(1, 12'd0, 1'b0, "R9 no grant when all occupied");
    for (int i = 0; i < 16; i++) start_ex((6 + i) % 16);
    for (int i = 0; i < 16; i++) finish((6 + i) % 16, 1'b0);
    step();
    chk(int'(ret_valid), 1, "R6 last drained slot");
    chk(int'(ret_tags[3:0]), 5, "R9 last tag after wrap");
    chk(int'(full_o), 0, "R3 full clears after drain");
  endtask

  // R7: exception behind an older slot, then flush
  task automatic t_exc;
    dispatch(3, {3'd0, 3'd4, 3'd3}, 1'b1, "R2 exc setup"); // tags 6,7,8
    start_ex(6);
    start_ex(7);
    start_ex(8);
    finish(7, 1'b1);
    finish(8, 1'b0);
    finish(6, 1'b0);
    chk(int'(ret_valid), 0, "R7 nothing retired before head finishes");
    step();
    chk(int'(ret_valid), 1, "R7 older slot retires alone");
    chk(int'(ret_tags[3:0]), 6, "R7 older tag");
    chk(int'(flush_o), 0, "R7 no flush yet");
    step();
    chk(int'(ret_valid), 1, "R7 excepting slot alone");
    chk(int'(ret_tags[3:0]), 7, "R7 excepting tag");
    chk(int'(ret_units[2:0]), 4, "R8 excepting unit code");
    chk(int'(ret_exc), 1, "R7 ret_exc");
    chk(int'(flush_o), 1, "R7 flush_o");
    chk(int'(full_o), 0, "R7 empty after flush");
    exp_tail = 8;
    step();
    chk(int'(ret_valid), 0, "R7 younger finished slot discarded");
    chk(int'(flush_o), 0, "R7 flush is one pulse");
    dispatch(4, 12'd0, 1'b1, "R7 tags restart after excepting slot");
  endtask

  initial begin
    rst = 1'b1;
    disp_cnt = '0; disp_unit = '0;
    ex_valid = 1'b0; ex_tag = '0;
    fin_valid = 1'b0; fin_tag = '0; fin_exc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_burst();
    t_ignored();
    t_full();
    t_exc();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule